// File: doc/BRIEF.md
# Flash Program/Erase Sequence Controller

This block is the control logic of an embedded flash controller. It sequences programming and erasing of a flash array that is divided into blocks. Software controls it through one small control register. That register holds a sequence-enable bit, a high-voltage-enable bit and a program/erase mode bit. While a sequence is open, word writes aimed at the array do not reach the bit cells. In program mode each such write is collected into a 64-byte page buffer; each block has its own buffer. In erase mode the first such write arms the erase of the block it addresses.

The controller also tags every array read it forwards. A read is normal, program-margin or erase-margin, depending on how far the sequence has progressed. Setting the high-voltage bit hands the collected work to a behavioural array-operation channel. On that channel the controller issues one program operation per written page, or one block erase, and waits for a done pulse after each one. Clearing the sequence-enable bit ends the sequence and discards every page buffer. The analog side is outside this block: high-voltage generation, pulse timing and the cells themselves.

Addresses are word addresses. The upper `$clog2(NBLK)` bits select the block, bits [BLK_AW-1:4] select the 16-word page inside the block, and bits [3:0] select the word in the page.

Top module: `flash_seq_ctl`

## Requirements
- R1: After reset `ctl_q` is 0, `stat_busy` and `stat_err` are 0, and `op_valid` and `arr_rd` are 0.
- R2: The control register encodes bit 0 as sequence enable, bit 1 as high-voltage enable, and bit 2 as mode (1 = erase, 0 = program). A write that takes bit 0 from 0 to 1 opens a sequence, clears `stat_err` and latches the mode. A write with bit 0 = 0 also loads the mode. `ctl_q` shows {mode, hv, seq} one cycle after the write.
- R3: A read request in cycle N appears on `arr_rd`/`arr_rd_addr` in cycle N+1.
- R4: In program mode, array writes inside an open sequence fill the page buffer of the addressed block. Once high voltage is accepted, one program operation is issued for each written block, lowest block first. `op_erase` is 0 on these operations. `op_addr` carries the page base (word offset 0), and `op_data[32*i+31:32*i]` holds word i. Words that were never written read as all ones.
- R5: Array writes are ignored when no sequence is open, and also once high voltage has been accepted.
- R6: In erase mode, the first array write of a sequence arms the erase and selects the block to erase; later array writes are ignored. High voltage then causes a single operation with `op_erase` = 1, where `op_addr` is the base of the armed block.
- R7: `arr_rd_margin` is 2'b01 (program margin) for reads after the first programming write and 2'b10 (erase margin) for reads after the interlock write. This lasts until the sequence is cleared. A read issued in the same cycle as the arming write is still normal (2'b00).
- R8: Setting high voltage before the sequence is armed is ignored: bit 1 of `ctl_q` stays 0 and `stat_err` becomes 1.
- R9: `stat_busy` is high from high-voltage acceptance until the done of the last operation. While busy, `op_valid` is high, and `op_addr`/`op_data` stay steady until `op_done`.
- R10: While `stat_busy` is high, control register writes are ignored.
- R11: Clearing sequence enable drops high voltage and returns reads to normal. It also invalidates all page buffers: data and written marks from the old sequence never reach a later program operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 3 | Control register write data |
| ctl_q | output | 3 | Control register contents {mode, hv, seq} |
| stat_busy | output | 1 | Array operations outstanding |
| stat_err | output | 1 | High voltage requested before arming |
| arr_wr | input | 1 | Word write to array address |
| arr_addr | input | AW | Word address of array write |
| arr_wdata | input | 32 | Array write data |
| rd_req | input | 1 | Array read request |
| rd_addr | input | AW | Word address of read |
| arr_rd | output | 1 | Read forwarded to array |
| arr_rd_addr | output | AW | Forwarded read address |
| arr_rd_margin | output | 2 | Read tag: 00 normal, 01 program margin, 10 erase margin |
| op_valid | output | 1 | Array operation request |
| op_erase | output | 1 | 1 = block erase, 0 = page program |
| op_addr | output | AW | Page base or block base word address |
| op_data | output | 512 | Page contents, word i at bits 32*i+31:32*i |
| op_done | input | 1 | Array operation completed |

## Verification
Register and array writes land at the clock edge that samples them. So `ctl_q`, `stat_err`, `stat_busy` and `op_valid` are due one cycle after the write, and a read is due on the forwarded port one cycle after its request, carrying the tag in force before that edge. After a done pulse, the next operation or the fall of busy appears in the following cycle. The bench drives every stimulus just after a rising edge, waits exactly one edge, and samples 1 ns later. It compares against values built from the written words. Several cases check that an ignored write or an unanswered request has changed nothing on the ports: waiting several cycles, register writes made while busy, and writes made outside the open window.

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl #(
  parameter int NBLK = 2,
  parameter int BLK_AW = 10,
  localparam int AW = $clog2(NBLK) + BLK_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_wdata,
  output logic [2:0]    ctl_q,
  output logic          stat_busy,
  output logic          stat_err,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic [31:0]   arr_wdata,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          arr_rd,
  output logic [AW-1:0] arr_rd_addr,
  output logic [1:0]    arr_rd_margin,
  output logic          op_valid,
  output logic          op_erase,
  output logic [AW-1:0] op_addr,
  output logic [511:0]  op_data,
  input  logic          op_done
);
  localparam int BKW = $clog2(NBLK);
  localparam int PGW = BLK_AW - 4;
  localparam int WPP = 16;

  logic seq, hv, mode, armed, err, busy;
  logic [NBLK-1:0] dirty, rest;
  logic [BKW-1:0]  ers_blk, cur, wblk;
  logic [PGW-1:0]  pg [NBLK];
  logic [31:0]     pbuf [NBLK][WPP];

  logic wr_ok, start, stop, prog_wr, lock_wr;

  assign wblk    = arr_addr[AW-1:BLK_AW];
  assign wr_ok   = reg_wr && !busy;
  assign start   = wr_ok && reg_wdata[0] && !seq;
  assign stop    = wr_ok && !reg_wdata[0];
  assign prog_wr = arr_wr && seq && !hv && !mode;
  assign lock_wr = arr_wr && seq && !hv && mode && !armed;

  always_comb begin
    cur = '0;
    for (int b = NBLK - 1; b >= 0; b--)
      if (dirty[b]) cur = BKW'(b);
  end
  assign rest = dirty & ~(NBLK'(1) << cur);

  assign ctl_q     = {mode, hv, seq};
  assign stat_busy = busy;
  assign stat_err  = err;
  assign op_valid  = busy;
  assign op_erase  = mode;
  assign op_addr   = mode ? {ers_blk, {BLK_AW{1'b0}}} : {cur, pg[cur], 4'b0};

  for (genvar w = 0; w < WPP; w++) begin : g_word
    assign op_data[32*w +: 32] = pbuf[cur][w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {seq, hv, mode, armed, err, busy} <= '0;
      dirty         <= '0;
      ers_blk       <= '0;
      arr_rd        <= 1'b0;
      arr_rd_addr   <= '0;
      arr_rd_margin <= 2'b00;
      for (int b = 0; b < NBLK; b++) begin
        pg[b] <= '0;
        for (int w = 0; w < WPP; w++) pbuf[b][w] <= '1;
      end
    end else begin
      arr_rd        <= rd_req;
      arr_rd_addr   <= rd_addr;
      arr_rd_margin <= (seq && armed) ? (mode ? 2'b10 : 2'b01) : 2'b00;

      if (prog_wr) begin
        pbuf[wblk][arr_addr[3:0]] <= arr_wdata;
        pg[wblk]    <= arr_addr[BLK_AW-1:4];
        dirty[wblk] <= 1'b1;
        armed       <= 1'b1;
      end
      if (lock_wr) begin
        ers_blk <= wblk;
        armed   <= 1'b1;
      end

      if (busy && op_done) begin
        if (mode || rest == '0) busy <= 1'b0;
        if (!mode) dirty[cur] <= 1'b0;
      end

      if (wr_ok) begin
        seq <= reg_wdata[0];
        if (start || stop) mode <= reg_wdata[2];
        if (stop) begin
          hv    <= 1'b0;
          armed <= 1'b0;
          dirty <= '0;
          for (int b = 0; b < NBLK; b++)
            for (int w = 0; w < WPP; w++) pbuf[b][w] <= '1;
        end else if (start) begin
          hv    <= 1'b0;
          armed <= 1'b0;
          err   <= 1'b0;
        end else if (reg_wdata[1] && !hv) begin
          if (armed) begin
            hv   <= 1'b1;
            busy <= 1'b1;
          end else begin
            err  <= 1'b1;
          end
        end else if (!reg_wdata[1]) begin
          hv <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/flash_seq_ctl_chk.sv
module flash_seq_ctl_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    ctl_q,
  input logic          stat_busy,
  input logic          stat_err,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          arr_rd,
  input logic [AW-1:0] arr_rd_addr,
  input logic [1:0]    arr_rd_margin,
  input logic          op_valid,
  input logic          op_done,
  input logic [AW-1:0] op_addr,
  input logic [511:0]  op_data
);
  a_r3_rd_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> arr_rd && arr_rd_addr == $past(rd_addr));

  a_r11_normal_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !ctl_q[0] |=> arr_rd_margin == 2'b00);

  a_r8_err_without_hv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err) |-> !ctl_q[1]);

  a_r9_busy_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy |-> ctl_q[1] && ctl_q[0] && op_valid);

  a_r9_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_done |=> op_valid && $stable(op_addr) && $stable(op_data));

  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy && reg_wr |=> $stable(ctl_q));
endmodule

bind flash_seq_ctl flash_seq_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ctl_q(ctl_q),
  .stat_busy(stat_busy), .stat_err(stat_err), .rd_req(rd_req),
  .rd_addr(rd_addr), .arr_rd(arr_rd), .arr_rd_addr(arr_rd_addr),
  .arr_rd_margin(arr_rd_margin), .op_valid(op_valid), .op_done(op_done),
  .op_addr(op_addr), .op_data(op_data)
);

// File: tb/sim_flash_seq_ctl.sv
`timescale 1ns/1ps
module sim_flash_seq_ctl;
  localparam int AW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, arr_wr = 1'b0, rd_req = 1'b0, op_done = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [AW-1:0] arr_addr = '0, rd_addr = '0;
  logic [31:0] arr_wdata = '0;
  logic [2:0] ctl_q;
  logic stat_busy, stat_err, arr_rd, op_valid, op_erase;
  logic [AW-1:0] arr_rd_addr, op_addr;
  logic [1:0] arr_rd_margin;
  logic [511:0] op_data, exp;

  int checks = 0, fails = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  flash_seq_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctl_q(ctl_q), .stat_busy(stat_busy), .stat_err(stat_err),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .arr_rd(arr_rd),
    .arr_rd_addr(arr_rd_addr), .arr_rd_margin(arr_rd_margin),
    .op_valid(op_valid), .op_erase(op_erase), .op_addr(op_addr),
    .op_data(op_data), .op_done(op_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, ex);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic regw(input logic [2:0] v);
    reg_wr = 1'b1; reg_wdata = v; tick(); reg_wr = 1'b0;
  endtask

  task automatic aw(input logic [AW-1:0] a, input logic [31:0] d);
    arr_wr = 1'b1; arr_addr = a; arr_wdata = d; tick(); arr_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] m, input string tag);
    rd_req = 1'b1; rd_addr = a; tick(); rd_req = 1'b0;
    chk(arr_rd && arr_rd_addr == a, "R3 read forward", 512'(arr_rd_addr), 512'(a));
    chk(arr_rd_margin == m, tag, 512'(arr_rd_margin), 512'(m));
  endtask

  task automatic done();
    op_done = 1'b1; tick(); op_done = 1'b0;
  endtask

  localparam int NV = 12;
  localparam logic [46:0] TBL [NV] = '{
    {2'd0, 11'h000, 32'h1,        2'b00},
    {2'd2, 11'h040, 32'h0,        2'b00},
    {2'd1, 11'h480, 32'hA5A5A5A5, 2'b00},
    {2'd2, 11'h000, 32'h0,        2'b01},
    {2'd0, 11'h000, 32'h0,        2'b00},
    {2'd2, 11'h000, 32'h0,        2'b00},
    {2'd0, 11'h000, 32'h5,        2'b00},
    {2'd2, 11'h000, 32'h0,        2'b00},
    {2'd1, 11'h010, 32'h0,        2'b00},
    {2'd2, 11'h400, 32'h0,        2'b10},
    {2'd0, 11'h000, 32'h0,        2'b00},
    {2'd2, 11'h000, 32'h0,        2'b00}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(ctl_q == 3'b000 && !stat_busy && !stat_err && !op_valid && !arr_rd, "R1 reset",
        512'({ctl_q, stat_busy, stat_err, op_valid, arr_rd}), 512'(0));

    // vector walk: R2 register readback, R7/R11 margin tags
    for (int i = 0; i < NV; i++) begin
      logic [46:0] e;
      e = TBL[i];
      case (e[46:45])
        2'd0: begin
          regw(e[4:2]);
          chk(ctl_q == e[4:2], "R2 ctl readback", 512'(ctl_q), 512'(e[4:2]));
        end
        2'd1: aw(e[44:34], e[33:2]);
        default: rd(e[44:34], e[1:0], "R7 margin tag");
      endcase
    end

    // program sequence, R4 R5 R7 R9 R10
    regw(3'b001);
    arr_wr = 1'b1; arr_addr = 11'h421; arr_wdata = 32'h11111111;
    rd_req = 1'b1; rd_addr = 11'h005;
    tick(); arr_wr = 1'b0; rd_req = 1'b0;
    chk(arr_rd_margin == 2'b00, "R7 same-cycle read normal", 512'(arr_rd_margin), 512'(0));
    aw(11'h000, 32'h22);
    aw(11'h00F, 32'h33);
    regw(3'b011);
    chk(stat_busy && op_valid && !op_erase && ctl_q == 3'b011, "R9 busy after hv",
        512'({stat_busy, op_valid, op_erase, ctl_q}), 512'(6'b110011));
    aw(11'h001, 32'h44);
    exp = '1; exp[31:0] = 32'h22; exp[15*32 +: 32] = 32'h33;
    chk(op_addr == 11'h000, "R4 first op block0 base", 512'(op_addr), 512'(0));
    chk(op_data == exp, "R5 late write ignored, R4 data", op_data, exp);
    regw(3'b000);
    chk(ctl_q == 3'b011, "R10 write ignored while busy", 512'(ctl_q), 512'(3'b011));
    tick(); tick();
    chk(op_valid && op_addr == 11'h000, "R9 op held without done", 512'(op_addr), 512'(0));
    done();
    exp = '1; exp[63:32] = 32'h11111111;
    chk(stat_busy && op_addr == 11'h420, "R4 second op page base", 512'(op_addr), 512'(11'h420));
    chk(op_data == exp, "R4 block1 data", op_data, exp);
    done();
    chk(!stat_busy && !op_valid, "R9 busy drops after last done", 512'({stat_busy, op_valid}), 512'(0));

    // clear and reprogram, R11 R5
    regw(3'b000);
    chk(ctl_q == 3'b000, "R11 hv dropped on clear", 512'(ctl_q), 512'(0));
    rd(11'h010, 2'b00, "R11 read normal after clear");
    aw(11'h402, 32'h66);
    regw(3'b001);
    aw(11'h400, 32'h55);
    regw(3'b011);
    exp = '1; exp[31:0] = 32'h55;
    chk(op_valid && op_addr == 11'h400, "R11 old block0 not reprogrammed", 512'(op_addr), 512'(11'h400));
    chk(op_data == exp, "R11 buffers invalidated, R5 closed write ignored", op_data, exp);
    done();
    chk(!stat_busy, "R4 only written blocks programmed", 512'(stat_busy), 512'(0));
    regw(3'b000);

    // erase sequence, R6
    regw(3'b101);
    aw(11'h48D, 32'h0);
    aw(11'h000, 32'h0);
    rd(11'h001, 2'b10, "R7 erase margin");
    regw(3'b111);
    chk(op_valid && op_erase && op_addr == 11'h400, "R6 erase armed block",
        512'({op_erase, op_addr}), 512'({1'b1, 11'h400}));
    done();
    chk(!stat_busy && !op_valid, "R6 single erase op", 512'({stat_busy, op_valid}), 512'(0));
    regw(3'b000);

    // error, R8
    regw(3'b001);
    regw(3'b011);
    chk(ctl_q == 3'b001 && stat_err && !op_valid, "R8 early hv ignored",
        512'({ctl_q, stat_err}), 512'({3'b001, 1'b1}));
    regw(3'b000);
    regw(3'b001);
    chk(!stat_err, "R2 start clears error", 512'(stat_err), 512'(0));
    regw(3'b000);

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule